// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Fast Set

This block keeps a 24-hour time of day as six BCD digits: tens and ones of hours, minutes and seconds. Everything runs on one system clock. A one-cycle pulse, `sec_tick`, arrives once per second and advances the seconds. The minutes advance when the seconds roll over, and the hours advance when the minutes roll over.

Four level controls arrive already debounced. Two of them are fast-set controls, one for hours and one for minutes. While a fast-set control is active, its field no longer follows the carry from the field below. It steps once on each `set_tick` pulse instead, and that pulse comes at about 2 Hz. The other two controls are a clear, which forces the time to midnight, and a hold, which stops all counting. The priority is fixed: clear first, then hold, then fast set, then normal counting. The six digits come straight from registers.

Top module: `tod_bcd_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all six digits read 0.
- R2: Each `sec_tick` pulse advances the seconds by one in BCD. The ones digit goes from 9 to 0 and carries into the tens digit, so the seconds run from 00 to 59 and then return to 00.
- R3: When the seconds go from 59 to 00 and minute set is inactive, the minutes advance by one in BCD (00 to 59, then back to 00).
- R4: When the minutes go from 59 to 00 and hour set is inactive, the hours advance by one in BCD. The hours run from 00 to 23, so 23:59:59 followed by one `sec_tick` gives 00:00:00.
- R5: In a cycle with no `sec_tick`, the seconds keep their value.
- R6: While `min_set` is high, the minutes advance once per `set_tick` and ignore the seconds carry. A minute wrap from 59 to 00 during set leaves the hours unchanged, and the seconds keep running.
- R7: While `hr_set` is high, the hours advance once per `set_tick`, wrapping from 23 to 00, and ignore the minutes carry.
- R8: While `clr` is high, all six digits become 0 at the next clock edge, whatever `hold`, the set controls and the ticks are doing.
- R9: While `hold` is high and `clr` is low, all six digits keep their values, even when ticks arrive and a set control is active.
- R10: The digits always hold legal values: each seconds or minutes tens digit is at most 5, every ones digit is at most 9, and the hours are at most 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| set_tick | input | 1 | One-cycle pulse at the fast-set rate |
| hr_set | input | 1 | Hour fast-set level |
| min_set | input | 1 | Minute fast-set level |
| clr | input | 1 | Clear-to-midnight level |
| hold | input | 1 | Freeze level |
| hr_tens | output | 4 | Hours tens digit, BCD |
| hr_ones | output | 4 | Hours ones digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| min_ones | output | 4 | Minutes ones digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| sec_ones | output | 4 | Seconds ones digit, BCD |

## Verification
The digits are the state, so a wrong internal value appears at the ports in the cycle after the faulty edge. A carry that is wrongly gated or a wrap that is misplaced stays hidden until the affected field reaches its top value, at 59 for seconds or minutes and at 23 for hours. For that reason the bench drives each field through its wrap under normal counting, under fast set and with hold or clear active at the same time. It compares every cycle against a time model of its own.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DIGIT_W = 4;
  localparam int NUM_FIELDS = 3;
  typedef logic [DIGIT_W-1:0] bcd_t;
  typedef struct packed {
    bcd_t tens;
    bcd_t ones;
  } bcd_pair_t;
endpackage

// File: rtl/tod_digit_pair.sv
module tod_digit_pair
  import tod_pkg::*;
#(
  parameter int MODULUS = 60
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  logic      adv,
  output bcd_pair_t val,
  output logic      at_top
);
  localparam int TOP   = MODULUS - 1;
  localparam bcd_t TOP_T = DIGIT_W'(TOP / 10);
  localparam bcd_t TOP_O = DIGIT_W'(TOP % 10);
  localparam bcd_t NINE  = DIGIT_W'(9);

  logic wrap_all;
  logic ones_wrap;

  // A wrap also covers any value above the top, so a field that somehow
  // holds an illegal value returns to zero on its next advance.
  always_comb begin
    at_top    = (val.tens == TOP_T) && (val.ones == TOP_O);
    wrap_all  = (val.tens > TOP_T) || ((val.tens == TOP_T) && (val.ones >= TOP_O));
    ones_wrap = (val.ones >= NINE);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      val <= '0;
    end else if (adv) begin
      if (wrap_all) begin
        val <= '0;
      end else if (ones_wrap) begin
        val.ones <= '0;
        val.tens <= val.tens + 1'b1;
      end else begin
        val.ones <= val.ones + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tod_adv_ctrl.sv
module tod_adv_ctrl
  import tod_pkg::*;
(
  input  logic                  sec_tick,
  input  logic                  set_tick,
  input  logic                  hr_set,
  input  logic                  min_set,
  input  logic                  clr,
  input  logic                  hold,
  input  logic [NUM_FIELDS-1:0] top,
  output logic [NUM_FIELDS-1:0] adv
);
  logic run;
  logic sec_wrap;
  logic min_wrap;

  // Field 0 is seconds, field 1 is minutes, field 2 is hours.
  always_comb begin
    run      = !clr && !hold;
    adv[0]   = run && sec_tick;
    sec_wrap = adv[0] && top[0];
    adv[1]   = run && (min_set ? set_tick : sec_wrap);
    min_wrap = adv[1] && top[1] && !min_set;
    adv[2]   = run && (hr_set ? set_tick : min_wrap);
  end
endmodule

// File: rtl/tod_bcd_core.sv
module tod_bcd_core
  import tod_pkg::*;
#(
  parameter int SEC_MOD = 60,
  parameter int MIN_MOD = 60,
  parameter int HR_MOD  = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sec_tick,
  input  logic               set_tick,
  input  logic               hr_set,
  input  logic               min_set,
  input  logic               clr,
  input  logic               hold,
  output logic [DIGIT_W-1:0] hr_tens,
  output logic [DIGIT_W-1:0] hr_ones,
  output logic [DIGIT_W-1:0] min_tens,
  output logic [DIGIT_W-1:0] min_ones,
  output logic [DIGIT_W-1:0] sec_tens,
  output logic [DIGIT_W-1:0] sec_ones
);
  localparam int FIELD_MOD [NUM_FIELDS] = '{SEC_MOD, MIN_MOD, HR_MOD};

  logic [NUM_FIELDS-1:0] adv;
  logic [NUM_FIELDS-1:0] top;
  bcd_pair_t             field [NUM_FIELDS];

  tod_adv_ctrl u_ctrl (
    .sec_tick (sec_tick),
    .set_tick (set_tick),
    .hr_set   (hr_set),
    .min_set  (min_set),
    .clr      (clr),
    .hold     (hold),
    .top      (top),
    .adv      (adv)
  );

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    tod_digit_pair #(.MODULUS(FIELD_MOD[i])) u_pair (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr),
      .adv    (adv[i]),
      .val    (field[i]),
      .at_top (top[i])
    );
  end

  assign sec_tens = field[0].tens;
  assign sec_ones = field[0].ones;
  assign min_tens = field[1].tens;
  assign min_ones = field[1].ones;
  assign hr_tens  = field[2].tens;
  assign hr_ones  = field[2].ones;
endmodule

// File: rtl/tod_bcd_core_chk.sv
module tod_bcd_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       sec_tick,
  input logic       set_tick,
  input logic       hr_set,
  input logic       min_set,
  input logic       clr,
  input logic       hold,
  input logic [3:0] hr_tens,
  input logic [3:0] hr_ones,
  input logic [3:0] min_tens,
  input logic [3:0] min_ones,
  input logic [3:0] sec_tens,
  input logic [3:0] sec_ones
);
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (hr_tens == 0 && hr_ones == 0 && min_tens == 0 &&
             min_ones == 0 && sec_tens == 0 && sec_ones == 0));

  p_hold_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (hold && !clr) |=> ($stable(hr_tens) && $stable(hr_ones) && $stable(min_tens) &&
                        $stable(min_ones) && $stable(sec_tens) && $stable(sec_ones)));

  p_idle_sec_r5: assert property (@(posedge clk) disable iff (rst)
    (!sec_tick && !clr) |=> ($stable(sec_tens) && $stable(sec_ones)));

  p_min_set_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (min_set && !set_tick && !clr) |=> ($stable(min_tens) && $stable(min_ones)));

  p_hr_set_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (hr_set && !set_tick && !clr) |=> ($stable(hr_tens) && $stable(hr_ones)));

  p_day_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !clr && !hold && !hr_set && !min_set &&
     hr_tens == 2 && hr_ones == 3 && min_tens == 5 && min_ones == 9 &&
     sec_tens == 5 && sec_ones == 9)
    |=> (hr_tens == 0 && hr_ones == 0 && min_tens == 0 &&
         min_ones == 0 && sec_tens == 0 && sec_ones == 0));

  p_legal_digits_r10: assert property (@(posedge clk) disable iff (rst)
    (sec_tens <= 5 && sec_ones <= 9 && min_tens <= 5 && min_ones <= 9 &&
     hr_ones <= 9 && (hr_tens < 2 || (hr_tens == 2 && hr_ones <= 3))));
endmodule

bind tod_bcd_core tod_bcd_core_chk u_chk (.*);

// File: tb/tod_bcd_core_test.sv
module tod_bcd_core_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_tick = 1'b0, set_tick = 1'b0, hr_set = 1'b0, min_set = 1'b0;
  logic clr = 1'b0, hold = 1'b0;
  logic [3:0] hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones;

  always #5 clk = ~clk;

  tod_bcd_core uut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .set_tick(set_tick),
    .hr_set(hr_set), .min_set(min_set), .clr(clr), .hold(hold),
    .hr_tens(hr_tens), .hr_ones(hr_ones), .min_tens(min_tens),
    .min_ones(min_ones), .sec_tens(sec_tens), .sec_ones(sec_ones)
  );

  typedef struct {
    int    h;
    int    m;
    int    s;
    string tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  int mh = 0, mm = 0, ms = 0;
  bit finished = 0;

  task automatic step(input logic st, input logic ste, input logic hs,
                      input logic mset, input logic c, input logic hd,
                      input string tag);
    exp_t e;
    int oh, om;
    bit sw, ma, mw, ha;
    @(negedge clk);
    sec_tick = st; set_tick = ste; hr_set = hs; min_set = mset; clr = c; hold = hd;
    oh = mh; om = mm;
    e.tag = tag;
    if (c) begin
      mh = 0; mm = 0; ms = 0;
    end else if (!hd) begin
      sw = st && (ms == 59);
      if (st) ms = (ms + 1) % 60;
      ma = mset ? ste : sw;
      mw = ma && (mm == 59) && !mset;
      if (ma) mm = (mm + 1) % 60;
      ha = hs ? ste : mw;
      if (ha) mh = (mh + 1) % 24;
      if (!mset && mm != om) e.tag = "R3";
      if (!hs && mh != oh) e.tag = "R4";
    end
    e.h = mh; e.m = mm; e.s = ms;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    exp_t e;
    int ah, am, as_;
    #1;
    if (q.size() != 0) begin
      e = q.pop_front();
      ah = hr_tens * 10 + hr_ones;
      am = min_tens * 10 + min_ones;
      as_ = sec_tens * 10 + sec_ones;
      total++;
      if (ah != e.h || am != e.m || as_ != e.s) begin
        bad++;
        $display("FAIL %s: actual %0d:%0d:%0d expected %0d:%0d:%0d",
                 e.tag, ah, am, as_, e.h, e.m, e.s);
      end
      total++;
      if (sec_tens > 5 || sec_ones > 9 || min_tens > 5 || min_ones > 9 ||
          hr_ones > 9 || ah > 23) begin
        bad++;
        $display("FAIL R10: actual digits %0d%0d:%0d%0d:%0d%0d expected legal BCD",
                 hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    total++;
    if ({hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones} != '0) begin
      bad++;
      $display("FAIL R1: actual %h expected 0",
               {hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones});
    end
    // R2 ticks on even cycles, R5 idle on odd; includes a minute carry (R3)
    for (int i = 0; i < 130; i++) step(i % 2 == 0, 0, 0, 0, 0, 0, (i % 2 == 0) ? "R2" : "R5");
    // R6 minute set with seconds running, passes a minute wrap
    for (int i = 0; i < 140; i++) step(1, i % 2 == 0, 0, 1, 0, 0, "R6");
    // R7 hour set passes 23 -> 00
    for (int i = 0; i < 30; i++) step(i % 3 == 0, 1, 1, 0, 0, 0, "R7");
    // Bring to 23:59:59 and roll the day over (R4)
    while (mh != 23) step(0, 1, 1, 0, 0, 0, "R7");
    while (mm != 59) step(0, 1, 0, 1, 0, 0, "R6");
    while (ms != 59) step(1, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0, "R4");
    // R9 hold blocks ticks and set stepping
    for (int i = 0; i < 8; i++) step(1, 1, i % 2 == 0, i % 2 == 1, 0, 1, "R9");
    for (int i = 0; i < 40; i++) step(1, 0, 0, 0, 0, 0, "R2");
    // R8 clear overrides hold and set
    step(1, 1, 1, 1, 1, 1, "R8");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 1, 0, "R8");
    step(0, 0, 0, 0, 0, 0, "R5");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule